// File: doc/BRIEF.md
# Sigma-Delta Control-Level Output

This block turns a 12-bit control word into a single-bit pulse stream. A low-pass filter outside the chip turns that stream into an analog level proportional to the word. Each channel is a first-order sigma-delta modulator. Its control word is loaded through a plain write-strobe register interface. The word is split across two byte registers, and a write to either half takes effect at once, without waiting for the other half.

Each channel also has a flag-enable bit. When that bit is set, modulation stops and the pin holds a static logic level equal to the word's top bit, so the pin can serve as a plain digital flag. The number of channels, the word width and the address width are parameters. Each channel owns two consecutive register addresses.

Top module: `sdo_ctrl_dac`

## Requirements
- R1: While reset is low at a clock edge, every channel's word, flag-enable bit and accumulator are cleared, and every `sd_out` bit reads 0 from the following cycle.
- R2: A write to address 2c (the upper register of channel c) loads `wr_data[7:0]` into word bits 11:4 at that clock edge and leaves bits 3:0 and the flag unchanged.
- R3: A write to address 2c+1 (the lower register of channel c) loads `wr_data[7:4]` into word bits 3:0 and `wr_data[0]` into the flag-enable bit, leaves bits 11:4 unchanged and ignores `wr_data[3:1]`.
- R4: The modulator uses a newly written half from the clock edge after the write, whether or not the other half has been written.
- R5: On each clock the 12-bit accumulator becomes (accumulator + word) mod 4096, and the carry out of that addition is registered as the modulated output bit.
- R6: With a constant word W and the flag clear, any 4096 consecutive output bits contain exactly W ones. The word is straight binary, so 0x000 gives no ones and 0xFFF gives 4095 ones.
- R7: Changing the word does not clear the accumulator. Only reset clears it.
- R8: While the flag-enable bit of a channel is 1, its `sd_out` equals bit 11 of its word, and it follows a write to that bit from the cycle after the write.
- R9: Channels are independent. A write to one channel's addresses changes neither the word, the flag nor the output sequence of another channel.
- R10: Writes to addresses at or above 2×NUM_CH change no channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | ADDR_W | Register address: 2c = upper, 2c+1 = lower of channel c |
| wr_data | input | WORD_W-LO_W | Write data byte |
| sd_out | output | NUM_CH | One pulse-stream (or static flag) output per channel |

## Verification
The bench builds the block with its default values: two channels, a 12-bit word with a 4-bit lower field, and a 3-bit address. Two channels allow checks that a write to one channel leaves the other alone. The 3-bit address leaves four addresses (4 to 7) that decode to no channel, so ignored writes can be exercised. A 12-bit word keeps a full 4096-cycle averaging window short enough to count the ones exactly for several words, including both ends of the scale. The same run also covers a word change that happens mid-accumulation.

// File: rtl/sdo_pkg.sv
// Shared definitions for the sigma-delta control-level output.
// Assumes each channel owns two consecutive register addresses.
package sdo_pkg;

    // Which half of a channel's control word a register holds
    typedef enum logic {
        SEL_HI = 1'b0,
        SEL_LO = 1'b1
    } half_sel_e;

    localparam int unsigned REGS_PER_CH = 2;

    // Address of one half-register of a channel
    function automatic int unsigned reg_addr(input int unsigned ch, input half_sel_e sel);
        return REGS_PER_CH * ch + int'(sel);
    endfunction

endpackage

// File: rtl/sdo_reg_bank.sv
// Holds one channel's control word and flag-enable bit.
// Decodes the write strobe against this channel's two addresses and
// updates each half on its own write, so the word changes at once.
// Assumes HI_W > LO_W, so that the flag bit and the nibble field do not overlap.
module sdo_reg_bank #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned LO_W   = 4,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CH_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-LO_W-1:0]   wr_data,
    output logic [WORD_W-1:0]        word_o,
    output logic                     flag_o
);
    localparam int unsigned HI_W = WORD_W - LO_W;
    localparam logic [ADDR_W-1:0] HI_ADDR =
        ADDR_W'(sdo_pkg::reg_addr(CH_IDX, sdo_pkg::SEL_HI));
    localparam logic [ADDR_W-1:0] LO_ADDR =
        ADDR_W'(sdo_pkg::reg_addr(CH_IDX, sdo_pkg::SEL_LO));

    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;
    logic            flag_q;
    logic            hit_hi;
    logic            hit_lo;

    // Address match for the two halves
    always_comb begin
        hit_hi = wr_en && (wr_addr == HI_ADDR);
        hit_lo = wr_en && (wr_addr == LO_ADDR);
    end

    // Register update: each half loads independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (hit_hi) begin
                hi_q <= wr_data;
            end
            if (hit_lo) begin
                lo_q   <= wr_data[HI_W-1 -: LO_W];
                flag_q <= wr_data[0];
            end
        end
    end

    // Assembled word and flag
    always_comb begin
        word_o = {hi_q, lo_q};
        flag_o = flag_q;
    end
endmodule

// File: rtl/sdo_accum.sv
// First-order sigma-delta core: a WORD_W-bit accumulator whose
// carry out is registered as the modulated bit each clock.
// Assumes the accumulator runs freely and only reset clears it.
module sdo_accum #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);
    logic [WORD_W-1:0] acc_q;
    logic              bit_q;
    logic [WORD_W:0]   sum;

    // Accumulator plus word, with the carry kept
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, word_i};
    end

    // Accumulator and carry registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else begin
            acc_q <= sum[WORD_W-1:0];
            bit_q <= sum[WORD_W];
        end
    end

    // Modulated bit output
    always_comb begin
        bit_o = bit_q;
    end
endmodule

// File: rtl/sdo_out_sel.sv
// Chooses the pin level: the modulated bit, or the word's top bit
// held statically while the flag-enable bit is set.
// Assumes both inputs are already registered.
module sdo_out_sel #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              flag_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              mod_bit_i,
    output logic              pin_o
);
    // Static level or modulated stream
    always_comb begin
        pin_o = flag_i ? word_i[WORD_W-1] : mod_bit_i;
    end
endmodule

// File: rtl/sdo_ctrl_dac.sv
// Multi-channel sigma-delta control-level output.
// Each channel has a register bank, a first-order modulator and an output select.
// Assumes NUM_CH * 2 <= 2**ADDR_W, and that the data width equals WORD_W-LO_W.
module sdo_ctrl_dac #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned WORD_W = 12,
    parameter int unsigned LO_W   = 4,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-LO_W-1:0] wr_data,
    output logic [NUM_CH-1:0]      sd_out
);
    logic [NUM_CH-1:0][WORD_W-1:0] ch_word;
    logic [NUM_CH-1:0]             ch_flag;
    logic [NUM_CH-1:0]             ch_mod;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sdo_reg_bank #(
            .WORD_W (WORD_W),
            .LO_W   (LO_W),
            .ADDR_W (ADDR_W),
            .CH_IDX (c)
        ) i_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .word_o  (ch_word[c]),
            .flag_o  (ch_flag[c])
        );

        sdo_accum #(
            .WORD_W (WORD_W)
        ) i_accum (
            .clk    (clk),
            .rst_n  (rst_n),
            .word_i (ch_word[c]),
            .bit_o  (ch_mod[c])
        );

        sdo_out_sel #(
            .WORD_W (WORD_W)
        ) i_sel (
            .flag_i    (ch_flag[c]),
            .word_i    (ch_word[c]),
            .mod_bit_i (ch_mod[c]),
            .pin_o     (sd_out[c])
        );
    end
endmodule

// File: rtl/sdo_ctrl_dac_chk.sv
// Assertion checker for sdo_ctrl_dac, attached with bind.
// Assumes the bound instance exposes ch_word and ch_flag.
module sdo_ctrl_dac_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned WORD_W = 12,
    parameter int unsigned LO_W   = 4,
    parameter int unsigned ADDR_W = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [WORD_W-LO_W-1:0]        wr_data,
    input logic [NUM_CH-1:0]             sd_out,
    input logic [NUM_CH-1:0][WORD_W-1:0] ch_word,
    input logic [NUM_CH-1:0]             ch_flag
);
    localparam int unsigned HI_W = WORD_W - LO_W;

    // Outputs are low in the cycle after any reset edge
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (sd_out == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * c + 1);

        // Upper write lands in bits above the nibble
        assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_HI) |=>
            (ch_word[c][WORD_W-1 -: HI_W] == $past(wr_data)));

        // Lower write lands in the nibble and the flag
        assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_LO) |=>
            (ch_word[c][LO_W-1:0] == $past(wr_data[HI_W-1 -: LO_W]) &&
             ch_flag[c] == $past(wr_data[0])));

        // No write to this channel leaves its state untouched
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_addr == A_HI || wr_addr == A_LO)) |=>
            ($stable(ch_word[c]) && $stable(ch_flag[c])));

        // Flag mode pins the output to the word's top bit
        assert_flag_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ch_flag[c] |-> (sd_out[c] == ch_word[c][WORD_W-1]));
    end
endmodule

bind sdo_ctrl_dac sdo_ctrl_dac_chk #(
    .NUM_CH (NUM_CH),
    .WORD_W (WORD_W),
    .LO_W   (LO_W),
    .ADDR_W (ADDR_W)
) i_sdo_ctrl_dac_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sd_out  (sd_out),
    .ch_word (ch_word),
    .ch_flag (ch_flag)
);

// File: tb/test_sdo_ctrl_dac.sv
module test_sdo_ctrl_dac;
    localparam int NCH      = 2;
    localparam int WW       = 12;
    localparam int LW       = 4;
    localparam int AW       = 3;
    localparam int DW       = WW - LW;
    localparam int CLK_PER  = 10;
    localparam int WDOG_CYC = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NCH-1:0] sd_out;

    int n_checks = 0;
    int n_errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    // Bench reference state, built from the requirements
    logic [WW-1:0] m_word [NCH];
    logic          m_flag [NCH];
    logic [WW-1:0] m_acc  [NCH];
    logic          m_bit  [NCH];

    sdo_ctrl_dac #(.NUM_CH(NCH), .WORD_W(WW), .LO_W(LW), .ADDR_W(AW)) i_sdo_ctrl_dac (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sd_out(sd_out));

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_pin(input int ch);
        return m_flag[ch] ? m_word[ch][WW-1] : m_bit[ch];
    endfunction

    // Reference model: R1, R2, R3, R5, R7, R9, R10
    always @(posedge clk) begin
        for (int ch = 0; ch < NCH; ch++) begin
            if (!rst_n) begin
                m_word[ch] <= '0; m_flag[ch] <= 1'b0;
                m_acc[ch]  <= '0; m_bit[ch]  <= 1'b0;
            end else begin
                {m_bit[ch], m_acc[ch]} <= {1'b0, m_acc[ch]} + {1'b0, m_word[ch]};
                if (wr_en && int'(wr_addr) == 2 * ch)
                    m_word[ch][WW-1:LW] <= wr_data;
                if (wr_en && int'(wr_addr) == 2 * ch + 1) begin
                    m_word[ch][LW-1:0] <= wr_data[DW-1 -: LW];
                    m_flag[ch] <= wr_data[0];
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            for (int ch = 0; ch < NCH; ch++)
                check(sd_out[ch] === exp_pin(ch), m_flag[ch] ? "R8 stream" : "R5 stream",
                      int'(sd_out[ch]), int'(exp_pin(ch)));
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    // Count ones over a full window for every channel
    task automatic count_window(input int exp0, input int exp1, input string tag);
        int n0 = 0;
        int n1 = 0;
        repeat (2) @(posedge clk);
        repeat (1 << WW) begin
            @(negedge clk);
            n0 += int'(sd_out[0]);
            n1 += int'(sd_out[1]);
        end
        check(n0 == exp0, {tag, " ch0"}, n0, exp0);
        check(n1 == exp1, {tag, " ch1 (R9)"}, n1, exp1);
    endtask

    task automatic set_word(input int ch, input int w, input bit flag);
        wr(2 * ch, w >> LW);
        wr(2 * ch + 1, ((w & 'hF) << LW) | 'hE | int'(flag));
    endtask

    // Watchdog
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5D0C_0A11));
        do_reset();
        // R1: outputs low after reset with a zero word
        repeat (5) begin
            @(negedge clk);
            check(sd_out == '0, "R1 reset out", int'(sd_out), 0);
        end
        model_on = 1'b1;

        // R7: word change mid-accumulation keeps the accumulator
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h80;
        @(posedge clk); #2;
        wr_data = 8'h7F;
        @(posedge clk); #2;
        wr_en = 1'b0;
        @(posedge clk); #2;
        check(sd_out[0] == 1'b0, "R7 acc 0xFF0", int'(sd_out[0]), 0);
        @(posedge clk); #2;
        check(sd_out[0] == 1'b1, "R7 carry kept", int'(sd_out[0]), 1);

        // R6 end points, R3 (lower bits 3:1 set but ignored), R9 independent channels
        set_word(0, 'h000, 1'b0); set_word(1, 'hFFF, 1'b0);
        count_window('h000, 'hFFF, "R6 ends");
        set_word(0, 'h001, 1'b0); set_word(1, 'h800, 1'b0);
        count_window('h001, 'h800, "R3 R6 low/mid");
        for (int k = 0; k < 2; k++) begin
            int w0 = $urandom_range(0, 4095);
            int w1 = $urandom_range(0, 4095);
            set_word(0, w0, 1'b0); set_word(1, w1, 1'b0);
            count_window(w0, w1, "R6 random");
        end

        // R4: upper half only, lower half kept from before
        set_word(0, 'h5A3, 1'b0);
        wr(0, 'h2C);
        count_window('h2C3, int'(m_word[1]), "R4 half write");

        // R10: out-of-range addresses change nothing
        for (int a = 2 * NCH; a < (1 << AW); a++) wr(a, 'hFF);
        count_window('h2C3, int'(m_word[1]), "R10 ignored");

        // R8: flag mode static level follows the word's top bit
        set_word(0, 'h800, 1'b1);
        @(negedge clk);
        check(sd_out[0] == 1'b1, "R8 flag high", int'(sd_out[0]), 1);
        wr(0, 'h7F);
        @(negedge clk);
        check(sd_out[0] == 1'b0, "R8 flag low", int'(sd_out[0]), 0);
        repeat (20) @(negedge clk);
        check(sd_out[0] == 1'b0, "R8 flag static", int'(sd_out[0]), 0);
        wr(1, 'h00);

        // Constrained random writes, checked by the model each cycle
        repeat (3000) begin
            @(posedge clk); #2;
            wr_en   = ($urandom_range(0, 3) == 0);
            wr_addr = AW'($urandom_range(0, (1 << AW) - 1));
            wr_data = DW'($urandom);
        end
        @(posedge clk); #2 wr_en = 1'b0;

        // R1: reset mid-run clears the words and the outputs
        do_reset();
        repeat (10) begin
            @(negedge clk);
            check(sd_out == '0, "R1 reset mid-run", int'(sd_out), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule